// File: doc/BRIEF.md
# Quad Down-Counting Timer

This block holds four independent 32-bit down-counters behind one small register bus. Each counter has a load register that sets the count at once, a background value that is taken in only when the counter wraps, a control byte, and a current-value register that software reads. In a typical setup one channel runs freely as a time base; the count is recovered by inverting the value read. A second channel raises periodic or one-shot events.

Every channel steps its count on its own prescaled tick. When the count passes from one to zero it records an event in a shared raw status vector. A shared mask gates that vector onto a single interrupt line. Software acknowledges an event by writing ones to a clear register.

The bus is a single-cycle access. A write takes effect at the clock edge on which `busSel`, `busEnable` and `busWrite` are all high. Read data is combinational on `busAddr`.

Top module: `quad_down_timer`

## Requirements
- R1: After reset every register reads zero, all counters are stopped and `irqOut` is low.
- R2: Word addresses (busAddr[1:0] = 00) select the registers as follows. 0x00 is the mask and can be read and written. 0x04 is raw status and 0x08 is masked status, both read-only. 0x0C is the write-one-to-clear register and reads zero. Channel n (0..3) has a window at 0x10 + 0x10*n, with the load register at +0x0, the current value at +0x4, control at +0x8 and the background value at +0xC. Any unaligned or unmapped address reads zero, and a write to it has no effect.
- R3: A write to the load register puts the written value into the count at that clock edge. This takes precedence over a tick in the same cycle. The load register reads back the last value written to it.
- R4: In the control byte, bit 7 enables the channel and bits [3:2] select the prescaler. Code 00 gives one tick per clock, 01 one tick per 16 clocks, 10 one tick per 256 clocks, and 11 behaves as 00. An enabled channel steps down by one on each tick.
- R5: With bit 0 (one-shot) clear and bit 6 (periodic) clear, a tick at zero wraps the count to all ones in the active width.
- R6: With bit 0 clear and bit 6 set, a tick at zero reloads the count from the background register. A write to the background register leaves the running count unchanged.
- R7: With bit 0 set, the count stays at zero once it reaches zero.
- R8: With bit 1 clear the channel is 16 bits wide. Only bits [15:0] count and wrap, and bits [31:16] of the current value read as zero. With bit 1 set it is 32 bits wide.
- R9: Raw bit n is set in the cycle after a tick of channel n steps the count from 1 to 0. Writing a 1 to bit n of 0x0C clears raw bit n. When a set and a clear fall in the same cycle, the set wins.
- R10: Masked status equals raw AND mask. `irqOut` is high when any masked bit is set.
- R11: A control write restarts the prescaler. Writing zero to control stops the channel, and its count then holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus and the counters |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Peripheral select |
| busEnable | input | 1 | Access phase |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational on the address |
| irqOut | output | 1 | OR of the masked status bits |

## Verification
Two events can fall in the same cycle: a channel stepping from 1 to 0, and a write to the clear register. The bench provokes this by running a channel with a five-tick period while it holds a clear write high for a dozen consecutive cycles. One of those cycles must then land on the set cycle. A reference model that gives the set precedence is compared with `irqOut` on every clock. It is also compared with the raw status read back after the burst, so a design that lets the clear win loses the event and is caught.

// File: rtl/qdt_pkg.sv
package qdt_pkg;
  localparam int DW = 32;

  // control byte bit positions
  localparam int CTL_EN  = 7;
  localparam int CTL_PER = 6;
  localparam int CTL_W32 = 1;
  localparam int CTL_ONE = 0;

  typedef struct packed {
    logic          wrLoad;
    logic          wrCtrl;
    logic          wrBgl;
    logic [DW-1:0] data;
  } chanStrobe_t;
endpackage

// File: rtl/qdt_chan.sv
module qdt_chan
  import qdt_pkg::*;
#(
  parameter int NARROW_W = 16,
  parameter int PRE_W    = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  chanStrobe_t   stb,
  output logic [DW-1:0] loadRd,
  output logic [DW-1:0] valRd,
  output logic [DW-1:0] ctlRd,
  output logic [DW-1:0] bglRd,
  output logic          zeroHit
);
  localparam logic [DW-1:0] NARROW_MASK = {{(DW-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [DW-1:0]    cntQ, bglQ, loadQ;
  logic [7:0]       ctlQ;
  logic [PRE_W-1:0] preQ, preLimit;
  logic [DW-1:0]    widthMask, curVal, nextVal;
  logic             tick;

  assign widthMask = ctlQ[CTL_W32] ? '1 : NARROW_MASK;
  assign curVal    = cntQ & widthMask;

  always_comb begin
    case (ctlQ[3:2])
      2'b01:   preLimit = PRE_W'(15);
      2'b10:   preLimit = PRE_W'(255);
      default: preLimit = '0;
    endcase
  end

  assign tick = ctlQ[CTL_EN] && (preQ == preLimit);

  always_comb begin
    if (curVal != '0)         nextVal = curVal - DW'(1);
    else if (ctlQ[CTL_ONE])   nextVal = curVal;
    else if (ctlQ[CTL_PER])   nextVal = bglQ;
    else                      nextVal = widthMask;
  end

  assign zeroHit = tick && !stb.wrLoad && !stb.wrCtrl && (curVal == DW'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ  <= '0;
      bglQ  <= '0;
      loadQ <= '0;
      ctlQ  <= '0;
      preQ  <= '0;
    end else begin
      if (stb.wrBgl) bglQ <= stb.data;
      if (stb.wrLoad) begin
        cntQ  <= stb.data;
        loadQ <= stb.data;
      end else if (tick && !stb.wrCtrl) begin
        cntQ <= nextVal;
      end
      if (stb.wrCtrl) begin
        ctlQ <= stb.data[7:0];
        preQ <= '0;
      end else if (ctlQ[CTL_EN]) begin
        preQ <= (preQ == preLimit) ? '0 : preQ + PRE_W'(1);
      end
    end
  end

  assign loadRd = loadQ;
  assign valRd  = curVal;
  assign ctlRd  = {{(DW-8){1'b0}}, ctlQ};
  assign bglRd  = bglQ;

  // R7: a finished one-shot channel stays at zero
  assert_oneshot_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctlQ[CTL_EN] && ctlQ[CTL_ONE] && curVal == '0 && !stb.wrLoad && !stb.wrCtrl)
      |=> (valRd == '0));

  // R11: a disabled channel keeps its count
  assert_stopped_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlQ[CTL_EN] && !stb.wrLoad) |=> $stable(cntQ));

  // R4: a nonzero count only holds or steps down by one
  assert_count_down_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctlQ[CTL_EN] && curVal != '0 && !stb.wrLoad && !stb.wrCtrl)
      |=> (valRd == $past(curVal) || valRd == $past(curVal) - DW'(1)));
endmodule

// File: rtl/qdt_ctrl.sv
module qdt_ctrl
  import qdt_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    busSel,
  input  logic                    busEnable,
  input  logic                    busWrite,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic [DW-1:0]           busWdata,
  output logic [DW-1:0]           busRdata,
  output chanStrobe_t [NCH-1:0]   stbVec,
  input  logic [NCH-1:0][DW-1:0]  loadRd,
  input  logic [NCH-1:0][DW-1:0]  valRd,
  input  logic [NCH-1:0][DW-1:0]  ctlRd,
  input  logic [NCH-1:0][DW-1:0]  bglRd,
  input  logic [NCH-1:0]          zeroHit,
  output logic                    irqOut
);
  localparam int WIN_W = ADDR_W - 4;

  logic [WIN_W-1:0] winIdx;
  logic [1:0]       regSel;
  logic             wordOk, wrEn, maskWr;
  logic [NCH-1:0]   maskQ, rawQ, clrVec, maskedVec;

  assign winIdx = busAddr[ADDR_W-1:4];
  assign regSel = busAddr[3:2];
  assign wordOk = (busAddr[1:0] == 2'b00);
  assign wrEn   = busSel && busEnable && busWrite && wordOk;
  assign maskWr = wrEn && (winIdx == '0) && (regSel == 2'd0);
  assign clrVec = (wrEn && (winIdx == '0) && (regSel == 2'd3)) ? busWdata[NCH-1:0] : '0;

  for (genvar g = 0; g < NCH; g++) begin : g_strobe
    logic hit;
    assign hit = wrEn && (winIdx == WIN_W'(g + 1));
    assign stbVec[g].wrLoad = hit && (regSel == 2'd0);
    assign stbVec[g].wrCtrl = hit && (regSel == 2'd2);
    assign stbVec[g].wrBgl  = hit && (regSel == 2'd3);
    assign stbVec[g].data   = busWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '0;
      rawQ  <= '0;
    end else begin
      if (maskWr) maskQ <= busWdata[NCH-1:0];
      rawQ <= (rawQ & ~clrVec) | zeroHit;
    end
  end

  assign maskedVec = rawQ & maskQ;
  assign irqOut    = |maskedVec;

  always_comb begin
    busRdata = '0;
    if (wordOk) begin
      if (winIdx == '0) begin
        case (regSel)
          2'd0:    busRdata = DW'(maskQ);
          2'd1:    busRdata = DW'(rawQ);
          2'd2:    busRdata = DW'(maskedVec);
          default: busRdata = '0;
        endcase
      end else begin
        for (int c = 0; c < NCH; c++) begin
          if (winIdx == WIN_W'(c + 1)) begin
            case (regSel)
              2'd0:    busRdata = loadRd[c];
              2'd1:    busRdata = valRd[c];
              2'd2:    busRdata = ctlRd[c];
              default: busRdata = bglRd[c];
            endcase
          end
        end
      end
    end
  end

  // R9: a set event is recorded even under a simultaneous clear
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    (|zeroHit) |=> ((rawQ & $past(zeroHit)) == $past(zeroHit)));

  // R9: cleared bits with no new event read zero afterwards
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (clrVec != '0 && zeroHit == '0) |=> ((rawQ & $past(clrVec)) == '0));

  // R10: the interrupt only rises after an event or a mask write
  assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> ($past(|zeroHit) || $past(maskWr)));
endmodule

// File: rtl/quad_down_timer.sv
module quad_down_timer
  import qdt_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int ADDR_W   = 8,
  parameter int NARROW_W = 16,
  parameter int PRE_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busEnable,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DW-1:0]     busWdata,
  output logic [DW-1:0]     busRdata,
  output logic              irqOut
);
  chanStrobe_t [NCH-1:0]  stbVec;
  logic [NCH-1:0][DW-1:0] loadRd, valRd, ctlRd, bglRd;
  logic [NCH-1:0]         zeroHit;

  qdt_ctrl #(.NCH(NCH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busSel(busSel), .busEnable(busEnable), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .stbVec(stbVec),
    .loadRd(loadRd), .valRd(valRd), .ctlRd(ctlRd), .bglRd(bglRd),
    .zeroHit(zeroHit), .irqOut(irqOut)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    qdt_chan #(.NARROW_W(NARROW_W), .PRE_W(PRE_W)) u_chan (
      .clk(clk), .rstN(rstN), .stb(stbVec[g]),
      .loadRd(loadRd[g]), .valRd(valRd[g]), .ctlRd(ctlRd[g]), .bglRd(bglRd[g]),
      .zeroHit(zeroHit[g])
    );
  end
endmodule

// File: tb/tb_quad_down_timer.sv
`timescale 1ns/1ps
module tb_quad_down_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busEnable = 1'b0, busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  quad_down_timer dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busEnable(busEnable),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irqOut(irqOut)
  );

  // behavioural reference model
  logic [31:0] mVal[4], mBgl[4], mLoad[4];
  logic [7:0]  mCtl[4];
  int          mPre[4];
  logic [3:0]  mRaw, mMask;

  function automatic int divOf(logic [7:0] c);
    if (c[3:2] == 2'b01) return 16;
    if (c[3:2] == 2'b10) return 256;
    return 1;
  endfunction

  function automatic logic [31:0] mskOf(logic [7:0] c);
    return c[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < 4; c++) begin
        mVal[c] = 0; mBgl[c] = 0; mLoad[c] = 0; mCtl[c] = 0; mPre[c] = 0;
      end
      mRaw = 0; mMask = 0;
    end else begin
      bit wr;
      logic [3:0] setBits, clr;
      wr = busSel && busEnable && busWrite && busAddr[1:0] == 2'b00;
      setBits = 0;
      clr = 0;
      for (int c = 0; c < 4; c++) begin
        int base, dv;
        logic [31:0] m, v;
        bit tk, ctlW;
        base = 16 + 16 * c;
        dv = divOf(mCtl[c]);
        m = mskOf(mCtl[c]);
        v = mVal[c] & m;
        tk = mCtl[c][7] && (mPre[c] == dv - 1);
        ctlW = wr && busAddr == 8'(base + 8);
        if (wr && busAddr == 8'(base)) begin
          mVal[c] = busWdata; mLoad[c] = busWdata;
        end else if (tk && !ctlW) begin
          if (v == 1) setBits[c] = 1'b1;
          if (v != 0) mVal[c] = v - 1;
          else if (mCtl[c][0]) mVal[c] = 0;
          else if (mCtl[c][6]) mVal[c] = mBgl[c];
          else mVal[c] = m;
        end
        if (wr && busAddr == 8'(base + 12)) mBgl[c] = busWdata;
        if (ctlW) begin
          mCtl[c] = busWdata[7:0]; mPre[c] = 0;
        end else if (mCtl[c][7]) begin
          mPre[c] = (mPre[c] == dv - 1) ? 0 : mPre[c] + 1;
        end
      end
      if (wr && busAddr == 8'h00) mMask = busWdata[3:0];
      if (wr && busAddr == 8'h0C) clr = busWdata[3:0];
      mRaw = (mRaw & ~clr) | setBits;
    end
  end

  function automatic logic [31:0] expRead(logic [7:0] a);
    int c;
    if (a[1:0] != 0) return 0;
    case (a)
      8'h00: return {28'b0, mMask};
      8'h04: return {28'b0, mRaw};
      8'h08: return {28'b0, mRaw & mMask};
      8'h0C: return 0;
      default: ;
    endcase
    if (a < 8'h10 || a >= 8'h50) return 0;
    c = (a >> 4) - 1;
    case (a[3:2])
      2'd0: return mLoad[c];
      2'd1: return mVal[c] & mskOf(mCtl[c]);
      2'd2: return {24'b0, mCtl[c]};
      default: return mBgl[c];
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // irq compared with the model on every clock (R10, R9)
  always @(negedge clk) begin
    if (rstN && !done)
      chk(irqOut == |(mRaw & mMask), "R10 irq", {31'b0, irqOut}, {31'b0, |(mRaw & mMask)});
  end

  task automatic wrReg(logic [7:0] a, logic [31:0] d, int hold = 1);
    @(negedge clk);
    busSel = 1; busEnable = 1; busWrite = 1; busAddr = a; busWdata = d;
    repeat (hold) @(negedge clk);
    busSel = 0; busEnable = 0; busWrite = 0;
  endtask

  task automatic rdChk(logic [7:0] a, string req);
    @(negedge clk);
    busSel = 1; busEnable = 1; busWrite = 0; busAddr = a;
    #1;
    chk(busRdata == expRead(a), req, busRdata, expRead(a));
    busSel = 0; busEnable = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1;
    // R1, R2: reset state across the map, plus an unaligned address
    for (int a = 0; a < 8'h54; a += 4) rdChk(8'(a), "R1 R2 reset read");
    rdChk(8'h15, "R2 unaligned");

    // R3, R4, R5: channel 0 free-running, 32-bit, divide by 1
    wrReg(8'h10, 32'd20);
    rdChk(8'h14, "R3 load immediate");
    wrReg(8'h18, 32'h82);
    idle(7);
    rdChk(8'h14, "R4 count div1");
    wrReg(8'h10, 32'd3);
    idle(6);
    rdChk(8'h14, "R5 wrap to all ones");
    rdChk(8'h04, "R9 raw set");
    rdChk(8'h10, "R3 load readback");

    // R6, R10: channel 1 periodic with background value
    wrReg(8'h00, 32'h2);
    wrReg(8'h2C, 32'd6);
    wrReg(8'h20, 32'd5);
    wrReg(8'h28, 32'hC2);
    idle(3);
    wrReg(8'h2C, 32'd9);
    rdChk(8'h24, "R6 bgl write leaves count");
    idle(12);
    rdChk(8'h24, "R6 periodic reload");
    rdChk(8'h08, "R10 masked status");
    wrReg(8'h0C, 32'h3);
    rdChk(8'h04, "R9 clear");

    // R9: set/clear collision, period 5 ticks, clear held 12 cycles
    wrReg(8'h2C, 32'd4);
    idle(12);
    wrReg(8'h0C, 32'h2, 12);
    rdChk(8'h04, "R9 set wins");
    wrReg(8'h28, 32'h0);
    wrReg(8'h0C, 32'hF);
    rdChk(8'h04, "R9 clear all");

    // R7, R8: channel 2 one-shot, 16-bit, divide by 16
    wrReg(8'h30, 32'h0001_0023);
    rdChk(8'h34, "R8 upper bits zero");
    wrReg(8'h38, 32'h85);
    idle(40);
    rdChk(8'h34, "R4 div16 count");
    idle(600);
    rdChk(8'h34, "R7 one-shot hold");
    rdChk(8'h04, "R9 one-shot event");
    // R8: 16-bit free-running wraps to 0xFFFF
    wrReg(8'h30, 32'h2);
    wrReg(8'h38, 32'h80);
    idle(5);
    rdChk(8'h34, "R8 narrow wrap");

    // R4, R11: channel 3 divide by 256, then code 11, then stop
    wrReg(8'h40, 32'd1000);
    wrReg(8'h48, 32'h8A);
    idle(700);
    rdChk(8'h44, "R4 div256 count");
    wrReg(8'h48, 32'h8E);
    idle(9);
    rdChk(8'h44, "R4 code 11 as div1");
    wrReg(8'h48, 32'h0);
    idle(20);
    rdChk(8'h44, "R11 stopped hold");
    rdChk(8'h48, "R11 control zero");
    wrReg(8'h00, 32'hF);
    rdChk(8'h08, "R10 masked all");

    idle(4);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule